// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a plain 32-bit register bus. It has three registers: control, reload data and live count. The input clock is divided twice. First a programmable prescaler divides it, then a power-of-two stage chosen by a two-bit select field. Each resulting tick decrements a 16-bit down-counter. When the counter runs out while the watchdog is armed, the block raises a system reset pulse of fixed width. It also reloads the counter from the data register.

Software keeps the system alive by writing the count register before it runs out (a "kick"). To change the reload value, software first clears the enable bit, because the data register ignores writes while enabled. To force an immediate reset, software loads the count with 1 and then arms the block.

Top module: `prescaled_watchdog`

## Requirements
- R1: After reset the control register reads 0, the data and count registers read 0x8000, and `sys_rst` is low.
- R2: Registers sit at offset 0x0 (control), 0x4 (reload data) and 0x8 (count); other offsets read 0. Control fields: bit 0 enable, bit 1 reset-enable, bits 9:8 clock select, bits 23:16 prescaler. All other control bits read 0.
- R3: One tick lasts (P+1)·2^(4+S) input clocks, with P the prescaler field and S the select field. The divide chain restarts from zero on every control write.
- R4: If the count holds D when control is written with both enables set, `sys_rst` rises at the (D+1)·T-th clock edge after that write, where T is the tick length. The count then reads the reload data value.
- R5: The counter advances and a reset can occur only while both enable and reset-enable are set. With either bit clear, the count holds its value and `sys_rst` stays low.
- R6: A write to the count register loads the written low 16 bits at that clock edge, whatever the watchdog state. A read of the count register returns the live value.
- R7: A write to the reload data register has no effect while the enable bit is set.
- R8: Each reset pulse holds `sys_rst` high for exactly 8 input clock cycles.
- R9: Loading the count with 1 and then arming with P=0 and S=0 raises `sys_rst` 32 clocks after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier (1 = write) |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| sys_rst | output | 1 | System reset pulse |

## Verification
Read data is combinational, so each read is sampled 1 ns after the address is driven. Each register write lands on the next rising edge. The bench counts rising edges from the control write edge and expects `sys_rst` to show at the negative edge that follows edge (D+1)·T. It checks that the counter has just reloaded at that same point. It then counts exactly 8 low-phase samples with the pulse high. The kick test schedules its write between ticks so that the expected expiry edge can be worked out tick by tick.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
   // register byte offsets
   localparam int OFS_CTRL = 0;
   localparam int OFS_DATA = 4;
   localparam int OFS_CNT  = 8;
   // control field positions
   localparam int BIT_EN   = 0;
   localparam int BIT_REN  = 1;
   localparam int SEL_LSB  = 8;
   localparam int PRE_LSB  = 16;

   typedef enum logic [1:0] {
      REG_CTRL,
      REG_DATA,
      REG_CNT,
      REG_NONE
   } reg_sel_e;
endpackage

// File: rtl/pwd_regs.sv
module pwd_regs
   import pwd_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 16,
   parameter int PRE_W  = 8,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  cnt_live,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              en_q,
   output logic              ren_q,
   output logic [PRE_W-1:0]  presc_q,
   output logic [SEL_W-1:0]  sel_q,
   output logic [CNT_W-1:0]  reload_q,
   output logic              ctrl_wr,
   output logic              data_wr,
   output logic              cnt_wr,
   output logic [CNT_W-1:0]  cnt_wdata
);
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1) << (CNT_W - 1);

   reg_sel_e rsel;
   logic     wdata_unused;

   always_comb begin
      if (bus_addr == ADDR_W'(OFS_CTRL))      rsel = REG_CTRL;
      else if (bus_addr == ADDR_W'(OFS_DATA)) rsel = REG_DATA;
      else if (bus_addr == ADDR_W'(OFS_CNT))  rsel = REG_CNT;
      else                                    rsel = REG_NONE;
   end

   assign ctrl_wr   = bus_sel && bus_wr && (rsel == REG_CTRL);
   assign data_wr   = bus_sel && bus_wr && (rsel == REG_DATA);
   assign cnt_wr    = bus_sel && bus_wr && (rsel == REG_CNT);
   assign cnt_wdata = bus_wdata[CNT_W-1:0];
   assign wdata_unused = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         ren_q    <= 1'b0;
         presc_q  <= '0;
         sel_q    <= '0;
         reload_q <= CNT_INIT;
      end else begin
         if (ctrl_wr) begin
            en_q    <= bus_wdata[BIT_EN];
            ren_q   <= bus_wdata[BIT_REN];
            presc_q <= bus_wdata[PRE_LSB +: PRE_W];
            sel_q   <= bus_wdata[SEL_LSB +: SEL_W];
         end
         // reload value is locked while the enable bit is set
         if (data_wr && !en_q) begin
            reload_q <= bus_wdata[CNT_W-1:0];
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (rsel)
         REG_CTRL: begin
            bus_rdata[BIT_EN]              = en_q;
            bus_rdata[BIT_REN]             = ren_q;
            bus_rdata[SEL_LSB +: SEL_W]    = sel_q;
            bus_rdata[PRE_LSB +: PRE_W]    = presc_q;
         end
         REG_DATA: bus_rdata[CNT_W-1:0] = reload_q;
         REG_CNT:  bus_rdata[CNT_W-1:0] = cnt_live;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pwd_tick_gen.sv
module pwd_tick_gen #(
   parameter int PRE_W   = 8,
   parameter int SEL_W   = 2,
   parameter int DIV_LOG = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PRE_W-1:0] presc,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W = DIV_LOG + (1 << SEL_W) - 1;

   logic [PRE_W-1:0] pcnt_q;
   logic [DIV_W-1:0] dcnt_q;
   logic [DIV_W-1:0] dmax;
   logic             pre_wrap;
   logic             div_wrap;

   assign dmax     = DIV_W'((32'd1 << (DIV_LOG + 32'(sel))) - 32'd1);
   assign pre_wrap = (pcnt_q == presc);
   assign div_wrap = (dcnt_q == dmax);
   assign tick     = run && !restart && pre_wrap && div_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
         dcnt_q <= '0;
      end else if (restart || !run) begin
         pcnt_q <= '0;
         dcnt_q <= '0;
      end else if (pre_wrap) begin
         pcnt_q <= '0;
         dcnt_q <= div_wrap ? '0 : dcnt_q + 1'b1;
      end else begin
         pcnt_q <= pcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pwd_counter.sv
module pwd_counter #(
   parameter int CNT_W      = 16,
   parameter int RST_CYCLES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt_q,
   output logic             sys_rst
);
   localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1) << (CNT_W - 1);

   logic expire;
   assign expire = tick && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= CNT_INIT;
      else if (load)   cnt_q <= load_val;
      else if (expire) cnt_q <= reload;
      else if (tick)   cnt_q <= cnt_q - 1'b1;
   end

   generate
      if (RST_CYCLES == 1) begin : g_pulse_one
         logic rst_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_q <= 1'b0;
            else        rst_q <= expire;
         end
         assign sys_rst = rst_q;
      end else begin : g_pulse_wide
         localparam int PW = $clog2(RST_CYCLES + 1);
         logic [PW-1:0] plen_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              plen_q <= '0;
            else if (expire)         plen_q <= PW'(RST_CYCLES);
            else if (plen_q != '0)   plen_q <= plen_q - 1'b1;
         end
         assign sys_rst = (plen_q != '0);
      end
   endgenerate
endmodule

// File: rtl/prescaled_watchdog.sv
module prescaled_watchdog
   import pwd_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 4,
   parameter int CNT_W      = 16,
   parameter int PRE_W      = 8,
   parameter int SEL_W      = 2,
   parameter int DIV_LOG    = 4,
   parameter int RST_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              sys_rst
);
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and DATA_W");
      end
      if (PRE_LSB + PRE_W > DATA_W || SEL_LSB + SEL_W > PRE_LSB) begin : g_bad_fields
         $error("control fields do not fit the data word");
      end
      if (RST_CYCLES < 1) begin : g_bad_pulse
         $error("RST_CYCLES must be at least 1");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("ADDR_W too small for the register offsets");
      end
   endgenerate

   logic             en_q, ren_q, armed;
   logic [PRE_W-1:0] presc_q;
   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] reload_q, cnt_q, cnt_wdata;
   logic             ctrl_wr, data_wr, cnt_wr, tick;

   assign armed = en_q && ren_q;

   pwd_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
      .PRE_W(PRE_W), .SEL_W(SEL_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_live(cnt_q),
      .bus_rdata(bus_rdata), .en_q(en_q), .ren_q(ren_q),
      .presc_q(presc_q), .sel_q(sel_q), .reload_q(reload_q),
      .ctrl_wr(ctrl_wr), .data_wr(data_wr), .cnt_wr(cnt_wr),
      .cnt_wdata(cnt_wdata)
   );

   pwd_tick_gen #(
      .PRE_W(PRE_W), .SEL_W(SEL_W), .DIV_LOG(DIV_LOG)
   ) u_tick (
      .clk(clk), .rst_n(rst_n), .run(armed), .restart(ctrl_wr),
      .presc(presc_q), .sel(sel_q), .tick(tick)
   );

   pwd_counter #(
      .CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)
   ) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_wr),
      .load_val(cnt_wdata), .reload(reload_q), .cnt_q(cnt_q),
      .sys_rst(sys_rst)
   );
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
   parameter int CNT_W      = 16,
   parameter int RST_CYCLES = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             armed,
   input logic             en,
   input logic             data_wr,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] cnt_wdata,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] reload,
   input logic             sys_rst
);
   localparam int HW = $clog2(RST_CYCLES + 2) + 1;
   logic [HW-1:0] hi_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_len_q <= '0;
      else if (sys_rst) hi_len_q <= hi_len_q + 1'b1;
      else              hi_len_q <= '0;
   end

   AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst) |-> hi_len_q == HW'(RST_CYCLES)); // R8

   AST_HOLD_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !cnt_wr) |=> $stable(cnt)); // R5

   AST_RST_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst) |-> $past(armed)); // R5

   AST_RELOAD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && en) |=> $stable(reload)); // R7

   AST_KICK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> cnt == $past(cnt_wdata)); // R6

   AST_EXPIRY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sys_rst) && !$past(cnt_wr)) |-> cnt == reload); // R4
endmodule

bind prescaled_watchdog pwd_checker #(
   .CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .armed(armed), .en(en_q),
   .data_wr(data_wr), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
   .cnt(cnt_q), .reload(reload_q), .sys_rst(sys_rst)
);

// File: tb/sim_prescaled_watchdog.sv
`timescale 1ns/1ps
module sim_prescaled_watchdog;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sys_rst;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   prescaled_watchdog u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .sys_rst(sys_rst)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   localparam logic [3:0] A_CTRL = 4'h0, A_DATA = 4'h4, A_CNT = 4'h8;

   typedef struct packed {
      logic [7:0]  p;
      logic [1:0]  s;
      logic [15:0] d;
      logic [15:0] due;   // edges from control write to reset rise
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{p: 8'd0, s: 2'd0, d: 16'd2, due: 16'd48},
      '{p: 8'd1, s: 2'd0, d: 16'd1, due: 16'd64},
      '{p: 8'd0, s: 2'd1, d: 16'd3, due: 16'd128},
      '{p: 8'd2, s: 2'd3, d: 16'd0, due: 16'd384},
      '{p: 8'd0, s: 2'd2, d: 16'd5, due: 16'd384}
   };

   function automatic logic [31:0] ctl(input logic [7:0] p, input logic [1:0] s,
                                       input logic ren, input logic en);
      return {8'h00, p, 6'h00, s, 6'h00, ren, en};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // called at a negative edge; the write lands on the next rising edge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic wait_rst_high(input int limit);
      int t0 = cyc;
      while (!sys_rst && cyc - t0 < limit) @(negedge clk);
   endtask

   task automatic wait_rst_low();
      while (sys_rst) @(negedge clk);
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   initial begin
      wait (cyc == 150000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v, v2;
      int e0, w;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
      rd(A_DATA, v); chk("R1 data", v, 32'h8000);
      rd(A_CNT, v);  chk("R1 count", v, 32'h8000);
      chk("R1 sys_rst", {31'd0, sys_rst}, 32'h0);

      // R2 field layout and unmapped offset
      wr(A_CTRL, 32'hFFFF_FFFC);
      rd(A_CTRL, v); chk("R2 ctrl readback", v, 32'h00FF_0300);
      rd(4'hC, v);   chk("R2 unmapped", v, 32'h0);

      // R7 reload locked while enable set (reset-enable clear)
      wr(A_CTRL, ctl(8'd0, 2'd0, 1'b0, 1'b1));
      wr(A_DATA, 32'h1234);
      rd(A_DATA, v); chk("R7 data locked", v, 32'h8000);

      // R5 enable alone: no counting, no reset
      wr(A_CNT, 32'd2);
      repeat (100) @(negedge clk);
      rd(A_CNT, v); chk("R5 enable only holds", v, 32'd2);
      chk("R5 enable only no reset", {31'd0, sys_rst}, 32'h0);

      // R5 reset-enable alone
      wr(A_CTRL, ctl(8'd0, 2'd0, 1'b1, 1'b0));
      repeat (100) @(negedge clk);
      rd(A_CNT, v); chk("R5 reset-enable only holds", v, 32'd2);

      // R3 R4 R8 timing table
      foreach (VECS[i]) begin
         wr(A_CTRL, 32'h0);
         wr(A_DATA, {16'h0, VECS[i].d});
         wr(A_CNT, {16'h0, VECS[i].d});
         wr(A_CTRL, ctl(VECS[i].p, VECS[i].s, 1'b1, 1'b1));
         e0 = cyc;
         wait_rst_high(2000);
         chk("R3 R4 expiry edge", cyc - e0, {16'h0, VECS[i].due});
         rd(A_CNT, v); chk("R4 reload at expiry", v, {16'h0, VECS[i].d});
         w = 0;
         while (sys_rst && w < 50) begin w++; @(negedge clk); end
         chk("R8 pulse width", w, 32'd8);
         wr(A_CTRL, 32'h0);
      end

      // R9 forced reset; reload comes from data (5 from last vector)
      wr(A_CNT, 32'd1);
      wr(A_CTRL, ctl(8'd0, 2'd0, 1'b1, 1'b1));
      e0 = cyc;
      wait_rst_high(500);
      chk("R9 forced reset edge", cyc - e0, 32'd32);
      rd(A_CNT, v); chk("R4 reload from data", v, 32'd5);
      wait_rst_low();

      // R6 kick between ticks postpones expiry
      wr(A_CTRL, 32'h0);
      wr(A_DATA, 32'd3);
      wr(A_CNT, 32'd3);
      wr(A_CTRL, ctl(8'd0, 2'd0, 1'b1, 1'b1));
      e0 = cyc;
      wait_until(e0 + 39);
      wr(A_CNT, 32'd3);
      rd(A_CNT, v); chk("R6 kick loads count", v, 32'd3);
      wait_until(e0 + 66);
      chk("R6 no reset at old deadline", {31'd0, sys_rst}, 32'h0);
      wait_rst_high(500);
      chk("R6 expiry after kick", cyc - e0, 32'd96);
      wait_rst_low();

      // R5 disarming freezes the count
      wr(A_CTRL, 32'h0);
      wr(A_CNT, 32'd5);
      wr(A_CTRL, ctl(8'd0, 2'd0, 1'b1, 1'b1));
      e0 = cyc;
      wait_until(e0 + 20);
      wr(A_CTRL, ctl(8'd0, 2'd0, 1'b0, 1'b1));
      rd(A_CNT, v); chk("R5 count before freeze", v, 32'd4);
      repeat (200) @(negedge clk);
      rd(A_CNT, v2); chk("R5 count frozen", v2, 32'd4);
      chk("R5 no reset when disarmed", {31'd0, sys_rst}, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule